// File: doc/BRIEF.md
# I2C EEPROM Target Protocol Engine

This block is an I2C target that behaves like a small serial EEPROM with a second, read-only identification space of 16 bytes. The bus lines SCL and SDA are sampled on a fast system clock. SDA is driven open-drain, and the block shows this as a single drive-low enable, `sda_low_o`. The block decodes the device address byte and either acknowledges it or stays silent. It supports byte write, page write, current-address read, random read (a dummy write followed by a repeated start), sequential read and identifier read.

Write data is held in a page staging buffer. It is copied into the internal register array only when a Stop ends the transfer. The copy starts a self-timed busy period of `WRITE_CYCLES` system clocks. While that period runs, every address byte is left unacknowledged, so a host can poll for completion with acknowledges. A write-protect input blocks array updates and has no effect on reads.

The block has a single address pointer, shared by both spaces. A separate pointer unit handles the pointer arithmetic: a full-range wrap for reads and a wrap within the page for writes. The identifier contents are computed from two parameters.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset `sda_low_o` is 0, every array byte is 0x00 and the address pointer is 0.
- R2: A device address byte is accepted only when bits 7..4 are 1010 (user array) or 1011 (identifier space) and bits 3..1 equal `dev_pins_i`. Bit 0 set to 1 means read and 0 means write. For any other byte, SDA stays released for the rest of the transfer.
- R3: Each accepted device address, word address and write data byte is acknowledged by holding SDA low through the ninth SCL clock. `sda_low_o` changes only while SCL is low.
- R4: A write is a device address, then a word address, then data bytes. The array changes only when a Stop ends the transfer. A repeated start before the Stop discards the staged bytes and starts no busy period.
- R5: During a write, only the low 3 address bits advance, so the write stays within its 8-byte page. Bytes beyond the eighth overwrite earlier bytes of the same transfer.
- R6: A committing Stop starts a busy period of `WRITE_CYCLES` clocks. Every device address byte in that period is left unacknowledged. After it, a matching address is acknowledged again.
- R7: While `wp_i` is 1, address and data bytes are still acknowledged, but the array is left unchanged and no busy period starts.
- R8: Read data leaves MSB first. A current-address read returns the byte at the pointer, which holds the last accessed address plus one.
- R9: When the host acknowledges a read byte, the next byte follows. In the user array the address wraps from the last byte to 0. A host NACK ends the read.
- R10: The identifier space is selected with 1011. After a dummy write of word address 0x80, the read returns byte k = 0xC3 XOR (k × 0x3B mod 256) for k = 0..15, and the index wraps from 15 to 0.
- R11: Writes aimed at the identifier space are acknowledged, never change its contents and start no busy period.
- R12: A Stop (SDA rising while SCL is high) releases SDA and returns the block to idle. A Start (SDA falling while SCL is high) restarts address decoding at any point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad (wired-AND value) |
| dev_pins_i | input | 3 | Hard-wired device address bits |
| wp_i | input | 1 | Write protect; 1 blocks array updates |
| sda_low_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench builds the block with `WRITE_CYCLES` = 400 and `dev_pins_i` tied to 101; all other parameters keep their default values. With a busy period this short, a poll issued right after a commit is refused, and a second poll lands after the period has ended, so both sides of acknowledge polling are exercised within a few bytes of bus traffic. The default 256-byte array and 8-byte page give the read wrap at 0xFF and the in-page write wrap. The 16-byte identifier space is long enough to show its own wrap inside one sequential read.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_WADDR, ST_WDATA, ST_ACK_OUT, ST_RDATA, ST_ACK_IN
  } ee_state_e;

  typedef enum logic [1:0] {PTR_HOLD, PTR_LOAD, PTR_INC_RD, PTR_INC_WR} ptr_op_e;

  localparam logic [3:0] SEL_ARRAY = 4'b1010;
  localparam logic [3:0] SEL_ID    = 4'b1011;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_in, line_s, line_q;
  assign line_in = {scl_i, sda_i};

  // one synchronizer chain per bus line, idle level high
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], line_in[g]};
    end
    assign line_s[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '1;
    else        line_q <= line_s;
  end

  assign scl_s    = line_s[1];
  assign sda_s    = line_s[0];
  assign scl_rise = line_s[1] & ~line_q[1];
  assign scl_fall = ~line_s[1] & line_q[1];
  assign start_ev = line_s[1] & line_q[1] & line_q[0] & ~line_s[0];
  assign stop_ev  = line_s[1] & line_q[1] & ~line_q[0] & line_s[0];
endmodule

// File: rtl/i2c_ee_ptr.sv
module i2c_ee_ptr
  import i2c_ee_pkg::*;
#(
  parameter int AW      = 8,
  parameter int PAGE_AW = 3,
  parameter int ID_AW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ptr_op_e       op,
  input  logic          id_space,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] nxt_rd, nxt_wr;

  // reads: whole-array wrap, or wrap inside the identifier window
  always_comb begin
    if (id_space) nxt_rd = {ptr[AW-1:ID_AW], ID_AW'(ptr[ID_AW-1:0] + 1'b1)};
    else          nxt_rd = AW'(ptr + 1'b1);
  end

  // writes: only the in-page bits advance
  assign nxt_wr = {ptr[AW-1:PAGE_AW], PAGE_AW'(ptr[PAGE_AW-1:0] + 1'b1)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else begin
      unique case (op)
        PTR_LOAD:   ptr <= load_val;
        PTR_INC_RD: ptr <= nxt_rd;
        PTR_INC_WR: ptr <= nxt_wr;
        default:    ptr <= ptr;
      endcase
    end
  end
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_ee_pkg::*;
#(
  parameter int         MEM_DEPTH    = 256,
  parameter int         PAGE_BYTES   = 8,
  parameter int         ID_BYTES     = 16,
  parameter int         WRITE_CYCLES = 250000,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [7:0] ID_SEED      = 8'hC3,
  parameter logic [7:0] ID_STEP      = 8'h3B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_pins_i,
  input  logic       wp_i,
  output logic       sda_low_o
);
  localparam int AW      = $clog2(MEM_DEPTH);
  localparam int PAGE_AW = $clog2(PAGE_BYTES);
  localparam int ID_AW   = $clog2(ID_BYTES);
  localparam int TW      = $clog2(WRITE_CYCLES + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  i2c_ee_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  ee_state_e            state_q, ret_q;
  logic [3:0]           bit_cnt_q;
  logic [7:0]           shift_q, tx_q;
  logic                 sda_low_q, id_space_q, host_ack_q, pend_q;
  logic [PAGE_BYTES-1:0] pvalid_q;
  logic [7:0]           pbuf [PAGE_BYTES];
  logic [7:0]           mem  [MEM_DEPTH];
  logic [7:0]           id_rom [ID_BYTES];
  logic [TW-1:0]        busy_cnt_q;
  logic [AW-1:0]        cur_ptr;
  ptr_op_e              ptr_op;

  // identifier contents come from the two parameters
  for (genvar g = 0; g < ID_BYTES; g++) begin : g_id
    assign id_rom[g] = ID_SEED ^ 8'(ID_STEP * 8'(g));
  end

  logic       busy, byte_done, dev_hit, tx_load, commit;
  logic [7:0] rd_byte;

  assign busy      = (busy_cnt_q != '0);
  assign byte_done = scl_fall && (bit_cnt_q == 4'd8) &&
                     (state_q == ST_DEV || state_q == ST_WADDR || state_q == ST_WDATA);
  assign dev_hit   = (shift_q[7:4] == SEL_ARRAY || shift_q[7:4] == SEL_ID) &&
                     (shift_q[3:1] == dev_pins_i) && !busy;
  assign tx_load   = scl_fall && ((state_q == ST_ACK_OUT && ret_q == ST_RDATA) ||
                                  (state_q == ST_ACK_IN && host_ack_q));
  assign commit    = stop_ev && pend_q && !id_space_q && !wp_i;
  assign rd_byte   = id_space_q ? id_rom[cur_ptr[ID_AW-1:0]] : mem[cur_ptr];

  always_comb begin
    ptr_op = PTR_HOLD;
    if (!start_ev && !stop_ev) begin
      if (byte_done && state_q == ST_WADDR)      ptr_op = PTR_LOAD;
      else if (byte_done && state_q == ST_WDATA) ptr_op = PTR_INC_WR;
      else if (tx_load)                          ptr_op = PTR_INC_RD;
    end
  end

  i2c_ee_ptr #(.AW(AW), .PAGE_AW(PAGE_AW), .ID_AW(ID_AW)) ptr_i (
    .clk(clk), .rst_n(rst_n), .op(ptr_op), .id_space(id_space_q),
    .load_val(shift_q[AW-1:0]), .ptr(cur_ptr)
  );

  // protocol sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  ret_q <= ST_IDLE;  bit_cnt_q <= '0;
      shift_q <= '0;  tx_q <= '0;  sda_low_q <= 1'b0;  id_space_q <= 1'b0;
      host_ack_q <= 1'b0;  pend_q <= 1'b0;  pvalid_q <= '0;
    end else if (start_ev) begin
      state_q <= ST_DEV;  bit_cnt_q <= '0;  sda_low_q <= 1'b0;
      pend_q <= 1'b0;  pvalid_q <= '0;
    end else if (stop_ev) begin
      state_q <= ST_IDLE;  sda_low_q <= 1'b0;  pend_q <= 1'b0;  pvalid_q <= '0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise && bit_cnt_q != 4'd8) begin
            shift_q   <= {shift_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end
          if (byte_done) begin
            bit_cnt_q <= '0;
            state_q   <= ST_ACK_OUT;
            sda_low_q <= 1'b1;
            ret_q     <= ST_WDATA;
            if (state_q == ST_DEV) begin
              if (!dev_hit) begin
                state_q   <= ST_IDLE;
                sda_low_q <= 1'b0;
              end else begin
                id_space_q <= (shift_q[7:4] == SEL_ID);
                ret_q      <= shift_q[0] ? ST_RDATA : ST_WADDR;
              end
            end
            if (state_q == ST_WDATA) begin
              pend_q <= 1'b1;
              pvalid_q[cur_ptr[PAGE_AW-1:0]] <= 1'b1;
            end
          end
        end
        ST_ACK_OUT: if (scl_fall) begin
          sda_low_q <= 1'b0;
          state_q   <= ret_q;
          bit_cnt_q <= '0;
          if (ret_q == ST_RDATA) begin
            tx_q      <= {rd_byte[6:0], 1'b0};
            sda_low_q <= ~rd_byte[7];
            bit_cnt_q <= 4'd1;
          end
        end
        ST_RDATA: if (scl_fall) begin
          if (bit_cnt_q == 4'd8) begin
            sda_low_q <= 1'b0;
            state_q   <= ST_ACK_IN;
          end else begin
            sda_low_q <= ~tx_q[7];
            tx_q      <= {tx_q[6:0], 1'b0};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end
        end
        ST_ACK_IN: begin
          if (scl_rise) host_ack_q <= ~sda_s;
          if (scl_fall) begin
            if (host_ack_q) begin
              tx_q      <= {rd_byte[6:0], 1'b0};
              sda_low_q <= ~rd_byte[7];
              bit_cnt_q <= 4'd1;
              state_q   <= ST_RDATA;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // page staging buffer
  always_ff @(posedge clk) begin
    if (byte_done && state_q == ST_WDATA && !start_ev && !stop_ev)
      pbuf[cur_ptr[PAGE_AW-1:0]] <= shift_q;
  end

  // array update on a committing Stop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pvalid_q[i]) mem[{cur_ptr[AW-1:PAGE_AW], PAGE_AW'(i)}] <= pbuf[i];
    end
  end

  // self-timed write period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt_q <= '0;
    else if (commit) busy_cnt_q <= TW'(WRITE_CYCLES);
    else if (busy)   busy_cnt_q <= busy_cnt_q - 1'b1;
  end

  assign sda_low_o = sda_low_q;
endmodule

// File: rtl/i2c_ee_checker.sv
module i2c_ee_checker #(
  parameter int WRITE_CYCLES = 250000
) (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_low_o,
  input logic busy,
  input logic stop_ev,
  input logic wp_i,
  input logic id_space
);
  int busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  // R3
  ack_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_low_o != $past(sda_low_o)) |-> !scl_s);

  // R6
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !$rose(sda_low_o));

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= WRITE_CYCLES);

  // R7
  wp_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wp_i && $past(wp_i)) |=> !busy);

  // R11
  id_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && id_space && stop_ev) |=> !busy);

  // R12
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_low_o);
endmodule

bind i2c_eeprom_target i2c_ee_checker #(.WRITE_CYCLES(WRITE_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_low_o(sda_low_o),
  .busy(busy), .stop_ev(stop_ev), .wp_i(wp_i), .id_space(id_space_q)
);

// File: tb/i2c_eeprom_target_tb_top.sv
module i2c_eeprom_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int WCYC       = 400;
  localparam logic [2:0] PINS = 3'b101;

  // table: {word address, data}
  localparam logic [15:0] VEC [6] = '{
    {8'h00, 8'h5A}, {8'h07, 8'h81}, {8'h3C, 8'hF0},
    {8'h80, 8'h12}, {8'hFF, 8'hC7}, {8'h41, 8'h6E}};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_host = 1'b1, wp = 1'b0;
  logic sda_low, sda_bus;
  assign sda_bus = sda_host & ~sda_low;

  i2c_eeprom_target #(.WRITE_CYCLES(WCYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .dev_pins_i(PINS), .wp_i(wp), .sda_low_o(sda_low));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_mem [256];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [20];
  logic all_ack, ok;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_host = 1'b1; hold(Q); scl = 1'b1; hold(Q);
    sda_host = 1'b0; hold(Q); scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_host = 1'b0; hold(Q); scl = 1'b1; hold(Q); sda_host = 1'b1; hold(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_host = b; hold(Q); scl = 1'b1; hold(2*Q); scl = 1'b0; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_host = 1'b1; hold(Q); scl = 1'b1; hold(Q);
    acked = ~sda_bus; hold(Q); scl = 1'b0; hold(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    d = '0;
    for (int i = 0; i < 8; i++) begin
      sda_host = 1'b1; hold(Q); scl = 1'b1; hold(Q);
      d = {d[6:0], sda_bus}; hold(Q); scl = 1'b0; hold(Q);
    end
    send_bit(~give_ack);
    sda_host = 1'b1;
  endtask

  function automatic logic [7:0] dev(input logic [3:0] sel, input logic rw);
    return {sel, PINS, rw};
  endfunction

  // write n bytes of wbuf at addr; all_ack collects every acknowledge
  task automatic write_seq(input logic [3:0] sel, input logic [7:0] addr, input int n);
    logic a;
    all_ack = 1'b1;
    bus_start();
    send_byte(dev(sel, 1'b0), a); all_ack &= a;
    send_byte(addr, a);           all_ack &= a;
    for (int i = 0; i < n; i++) begin send_byte(wbuf[i], a); all_ack &= a; end
    bus_stop();
  endtask

  task automatic poll_once(output logic acked);
    bus_start(); send_byte(dev(4'b1010, 1'b0), acked); bus_stop();
  endtask

  task automatic wait_ready(output logic acked);
    acked = 1'b0;
    for (int i = 0; i < 12 && !acked; i++) poll_once(acked);
  endtask

  task automatic read_from(input logic [3:0] sel, input logic [7:0] addr, input int n);
    logic a;
    all_ack = 1'b1;
    bus_start();
    send_byte(dev(sel, 1'b0), a); all_ack &= a;
    send_byte(addr, a);           all_ack &= a;
    bus_start();
    send_byte(dev(sel, 1'b1), a); all_ack &= a;
    for (int i = 0; i < n; i++) recv_byte(i != n-1, rbuf[i]);
    bus_stop();
  endtask

  task automatic read_cur(input int n);
    logic a;
    bus_start();
    send_byte(dev(4'b1010, 1'b1), a); all_ack = a;
    for (int i = 0; i < n; i++) recv_byte(i != n-1, rbuf[i]);
    bus_stop();
  endtask

  function automatic logic [7:0] id_val(input int k);
    return 8'hC3 ^ 8'(8'h3B * 8'(k % 16));
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] a8;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    hold(5); rst_n = 1'b1; hold(5);

    // R1: released bus, pointer 0, array zero
    chk("R1 sda released", int'(sda_low), 0);
    read_cur(1);
    chk("R1 ack", int'(all_ack), 1);
    chk("R1 byte at pointer 0", int'(rbuf[0]), 8'h00);

    // table walk: byte write, poll, random read (R3 R4 R8)
    for (int v = 0; v < 6; v++) begin
      wbuf[0] = VEC[v][7:0];
      write_seq(4'b1010, VEC[v][15:8], 1);
      chk("R3 write acks", int'(all_ack), 1);
      exp_mem[VEC[v][15:8]] = VEC[v][7:0];
      wait_ready(ok);
      chk("R6 ready after busy", int'(ok), 1);
      read_from(4'b1010, VEC[v][15:8], 1);
      chk("R8 readback", int'(rbuf[0]), int'(exp_mem[VEC[v][15:8]]));
    end

    // R2: wrong pins and wrong nibble get no acknowledge
    bus_start(); send_byte({4'b1010, ~PINS, 1'b0}, ok); bus_stop();
    chk("R2 pin mismatch nack", int'(ok), 0);
    bus_start(); send_byte({4'b0110, PINS, 1'b1}, ok); bus_stop();
    chk("R2 nibble mismatch nack", int'(ok), 0);

    // R6: poll straight after a commit is refused, later accepted
    wbuf[0] = 8'h33;
    write_seq(4'b1010, 8'h20, 1); exp_mem[8'h20] = 8'h33;
    poll_once(ok);
    chk("R6 nack while busy", int'(ok), 0);
    wait_ready(ok);
    chk("R6 ack after busy", int'(ok), 1);
    read_from(4'b1010, 8'h20, 1);
    chk("R6 committed byte", int'(rbuf[0]), 8'h33);

    // R4: repeated start before Stop discards the data
    bus_start();
    send_byte(dev(4'b1010, 1'b0), ok); send_byte(8'h30, ok); send_byte(8'hAA, ok);
    bus_start(); send_byte(dev(4'b1010, 1'b1), ok);
    recv_byte(1'b0, rbuf[0]); bus_stop();
    poll_once(ok);
    chk("R4 no busy after aborted write", int'(ok), 1);
    read_from(4'b1010, 8'h30, 1);
    chk("R4 aborted byte not stored", int'(rbuf[0]), int'(exp_mem[8'h30]));

    // R5: ten bytes from 0x45 wrap inside page 0x40
    for (int i = 0; i < 10; i++) wbuf[i] = 8'(8'h60 + i);
    write_seq(4'b1010, 8'h45, 10);
    for (int i = 0; i < 10; i++) exp_mem[{5'b01000, 3'(5 + i)}] = wbuf[i];
    wait_ready(ok);
    read_from(4'b1010, 8'h40, 9);
    for (int i = 0; i < 9; i++)
      chk("R5 page rollover", int'(rbuf[i]), int'(exp_mem[8'h40 + i]));

    // R9: sequential read wraps at the array end
    read_from(4'b1010, 8'hFE, 4);
    for (int i = 0; i < 4; i++) begin
      a8 = 8'(8'hFE + i);
      chk("R9 sequential wrap", int'(rbuf[i]), int'(exp_mem[a8]));
    end

    // R8: current address follows the last read (0x01 + 1)
    read_cur(1);
    chk("R8 current address", int'(rbuf[0]), int'(exp_mem[8'h02]));

    // R7: write protect keeps array and skips busy
    wp = 1'b1; hold(4);
    wbuf[0] = 8'h99;
    write_seq(4'b1010, 8'h50, 1);
    chk("R7 acks under protect", int'(all_ack), 1);
    poll_once(ok);
    chk("R7 no busy period", int'(ok), 1);
    read_from(4'b1010, 8'h50, 1);
    chk("R7 array unchanged", int'(rbuf[0]), int'(exp_mem[8'h50]));
    wp = 1'b0; hold(4);

    // R10: identifier read with wrap after 16 bytes
    read_from(4'b1011, 8'h80, 18);
    chk("R10 acks", int'(all_ack), 1);
    for (int k = 0; k < 18; k++) chk("R10 identifier byte", int'(rbuf[k]), int'(id_val(k)));

    // R11: identifier write has no effect and no busy
    wbuf[0] = 8'h00; wbuf[1] = 8'h11;
    write_seq(4'b1011, 8'h80, 2);
    poll_once(ok);
    chk("R11 no busy", int'(ok), 1);
    read_from(4'b1011, 8'h80, 2);
    chk("R11 id byte 0 kept", int'(rbuf[0]), int'(id_val(0)));
    chk("R11 id byte 1 kept", int'(rbuf[1]), int'(id_val(1)));

    // R12: after a Stop the line is released
    hold(4);
    chk("R12 released after stop", int'(sda_low), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule